// File: doc/BRIEF.md
# Dual-Mode Clock-Crossing FIFO with Programmable Flags

This block stores words between a write clock domain and an independent read clock domain. It offers two ways to read. In standard mode the consumer must ask for each word with a read strobe, and the word appears on the output register at that read edge. In fall-through mode the oldest stored word is moved to the output on its own, and a ready flag tells the consumer that the output holds valid data. The `fwft_mode` pin selects the mode. It is meant to change only while reset is held.

Each domain computes its own status. The read side drives an empty / output-ready flag and an almost-empty flag. The write side drives a full / input-ready flag, an almost-full flag and a half-full flag. The two thresholds are loaded over the write data bus. While `load_en` is high, each write-enabled edge fills the next threshold register in a fixed rotation instead of storing a word. Pointers cross between domains as Gray code through two-flop synchronisers, so a flag can trail an event in the other domain by a few cycles.

Top module: `dual_mode_fifo`

## Requirements
- R1: A synchronous reset (high) empties the FIFO and sets both thresholds to 7. After reset, standard mode shows empty_or_rdy=1 and full_or_irdy=0. Fall-through mode shows empty_or_rdy=0 and full_or_irdy=1. In both modes almost_empty=1, almost_full=0, half_full=0, and rd_data=0.
- R2: In standard mode, words leave in the order written. A word written into an empty FIFO does not reach rd_data until a read. rd_data takes the next word at the rd_clk edge where rd_en=1 and the FIFO is not empty.
- R3: In fall-through mode, the oldest word reaches rd_data without rd_en, and empty_or_rdy goes to 1 within four rd_clk edges of the write. rd_en with empty_or_rdy=1 replaces rd_data with the next word, or drops empty_or_rdy when no word is left.
- R4: full_or_irdy reports full (1) in standard mode once 2^AW words are stored. In fall-through mode it reports input-ready (1) and drops to 0 once 2^AW words sit behind the output register, which is 2^AW+1 words in total.
- R5: A write while the write side sees the FIFO full is dropped, and the dropped word is never read out.
- R6: A read in standard mode while empty, or in fall-through mode while empty_or_rdy=0, leaves rd_data unchanged.
- R7: While load_en=1, each wr_en edge stores wr_data[AW-1:0] into a threshold register instead of the FIFO. The first edge goes to the almost-empty threshold, the second to the almost-full threshold, then back to almost-empty, and so on. Dropping load_en restarts the rotation at almost-empty.
- R8: almost_empty=1 when the read-side occupancy is at or below the almost-empty threshold. In fall-through mode that occupancy counts the word held on rd_data.
- R9: almost_full=1 when 2^AW minus the write-side count is at or below the almost-full threshold. The write-side count excludes a word already moved to the output.
- R10: half_full=1 when the write-side count exceeds 2^(AW-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| fwft_mode | input | 1 | 0 = standard read timing, 1 = fall-through timing |
| wr_en | input | 1 | Write strobe (word or threshold) |
| load_en | input | 1 | Routes write strobes to the threshold registers |
| wr_data | input | DW | Write data; low AW bits carry a threshold during load |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Registered output word |
| empty_or_rdy | output | 1 | Empty (standard) or output-ready (fall-through) |
| full_or_irdy | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_empty | output | 1 | Occupancy at or below the almost-empty threshold |
| almost_full | output | 1 | Free space at or below the almost-full threshold |
| half_full | output | 1 | More than half the depth is stored |

## Verification
Two pairs of events can meet in one cycle. The first is a write strobe that reaches a full FIFO: the bench fills the store exactly to capacity in each mode, issues one more write, and then drains everything to confirm that the extra word never appears. The second is a read strobe that reaches an empty or not-ready output: it is issued after a full drain, and the bench confirms that rd_data keeps its last word. The threshold rotation is tested across two load sessions. A broken rotation or restart would move the almost flags by whole levels in the following fill sweep, and the bench computes each flag arithmetically at every fill level.

// File: rtl/dmf_pkg.sv
`timescale 1ns/1ps
package dmf_pkg;
    localparam int GRAY_W    = 16;
    localparam int OFS_RESET = 7;

    typedef enum logic {
        SEL_AE = 1'b0,
        SEL_AF = 1'b1
    } ofs_sel_e;

    function automatic logic [GRAY_W-1:0] bin_to_gray(input logic [GRAY_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GRAY_W-1:0] gray_to_bin(input logic [GRAY_W-1:0] g);
        logic [GRAY_W-1:0] b;
        b[GRAY_W-1] = g[GRAY_W-1];
        for (int i = GRAY_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction
endpackage

// File: rtl/dmf_sync.sv
`timescale 1ns/1ps
module dmf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dmf_wr_ctl.sv
`timescale 1ns/1ps
module dmf_wr_ctl import dmf_pkg::*; #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_mode,
    input  logic          wr_en,
    input  logic          load_en,
    input  logic [AW-1:0] ofs_data,
    input  logic [AW:0]   rgray_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW:0]   wgray,
    output logic          full_or_irdy,
    output logic          almost_full,
    output logic          half_full,
    output logic [AW-1:0] ae_ofs
);
    localparam int PW = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

    logic [PW-1:0] wptr, wptr_nx, rbin, used, free_slots;
    logic          full, push;
    ofs_sel_e      sel;
    logic [AW-1:0] af_ofs;

    assign rbin       = PW'(gray_to_bin(GRAY_W'(rgray_s)));
    assign used       = wptr - rbin;
    assign full       = (used == DEPTH_P);
    assign free_slots = DEPTH_P - used;
    assign push       = wr_en & ~load_en & ~full;
    assign wptr_nx    = wptr + PW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr   <= '0;
            wgray  <= '0;
            sel    <= SEL_AE;
            ae_ofs <= AW'(OFS_RESET);
            af_ofs <= AW'(OFS_RESET);
        end else begin
            if (push) begin
                wptr  <= wptr_nx;
                wgray <= PW'(bin_to_gray(GRAY_W'(wptr_nx)));
            end
            if (!load_en) begin
                sel <= SEL_AE;
            end else if (wr_en) begin
                if (sel == SEL_AE) ae_ofs <= ofs_data;
                else               af_ofs <= ofs_data;
                sel <= (sel == SEL_AE) ? SEL_AF : SEL_AE;
            end
        end
    end

    assign mem_we       = push;
    assign mem_addr     = wptr[AW-1:0];
    assign full_or_irdy = fwft_mode ? ~full : full;
    assign almost_full  = (free_slots <= PW'(af_ofs));
    assign half_full    = (used > HALF_P);

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !load_en && full) |=> $stable(wptr))
        else $error("write accepted while full");

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (rst)
        used <= DEPTH_P)
        else $error("write-side count beyond depth");

    assert_load_no_store_R7: assert property (@(posedge clk) disable iff (rst)
        load_en |=> $stable(wptr))
        else $error("threshold load moved the write pointer");
endmodule

// File: rtl/dmf_rd_ctl.sv
`timescale 1ns/1ps
module dmf_rd_ctl import dmf_pkg::*; #(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft_mode,
    input  logic          rd_en,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] mem_rdata,
    input  logic [AW-1:0] ae_ofs,
    output logic [AW-1:0] mem_addr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          empty_or_rdy,
    output logic          almost_empty
);
    localparam int PW = AW + 1;
    localparam int OW = AW + 2;
    localparam int DEPTH = 1 << AW;

    logic [PW-1:0] rptr, rptr_nx, wbin, mem_cnt;
    logic [OW-1:0] occ;
    logic          mem_has, ovalid, fetch;

    assign wbin    = PW'(gray_to_bin(GRAY_W'(wgray_s)));
    assign mem_cnt = wbin - rptr;
    assign mem_has = (mem_cnt != '0);
    assign rptr_nx = rptr + PW'(1);
    assign fetch   = fwft_mode ? (mem_has && (!ovalid || rd_en))
                               : (mem_has && rd_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr    <= '0;
            rgray   <= '0;
            rd_data <= '0;
            ovalid  <= 1'b0;
        end else begin
            if (fetch) begin
                rptr    <= rptr_nx;
                rgray   <= PW'(bin_to_gray(GRAY_W'(rptr_nx)));
                rd_data <= mem_rdata;
            end
            if (!fwft_mode)   ovalid <= 1'b0;
            else if (fetch)   ovalid <= 1'b1;
            else if (rd_en)   ovalid <= 1'b0;
        end
    end

    assign occ          = fwft_mode ? (OW'(mem_cnt) + OW'(ovalid)) : OW'(mem_cnt);
    assign mem_addr     = rptr[AW-1:0];
    assign empty_or_rdy = fwft_mode ? ovalid : ~mem_has;
    assign almost_empty = (occ <= OW'(ae_ofs));

    assert_empty_read_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!fwft_mode && rd_en && empty_or_rdy) |=> $stable(rd_data))
        else $error("standard-mode read on empty changed the output");

    assert_drain_clears_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (fwft_mode && rd_en && empty_or_rdy && !mem_has) |=> !empty_or_rdy)
        else $error("ready stayed high after last word was taken");

    assert_occ_bound_R8: assert property (@(posedge clk) disable iff (rst)
        occ <= OW'(DEPTH + 1))
        else $error("read-side occupancy beyond capacity");
endmodule

// File: rtl/dual_mode_fifo.sv
`timescale 1ns/1ps
module dual_mode_fifo #(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          rst,
    input  logic          fwft_mode,
    input  logic          wr_en,
    input  logic          load_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          empty_or_rdy,
    output logic          full_or_irdy,
    output logic          almost_empty,
    output logic          almost_full,
    output logic          half_full
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          mem_we;
    logic [AW-1:0] waddr, raddr, ae_ofs;
    logic [AW:0]   wgray, wgray_s, rgray, rgray_s;
    logic [DW-1:0] mem_rdata;

    always_ff @(posedge wr_clk) begin
        if (mem_we) mem[waddr] <= wr_data;
    end
    assign mem_rdata = mem[raddr];

    dmf_wr_ctl #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst(rst), .fwft_mode(fwft_mode),
        .wr_en(wr_en), .load_en(load_en), .ofs_data(wr_data[AW-1:0]),
        .rgray_s(rgray_s), .mem_we(mem_we), .mem_addr(waddr), .wgray(wgray),
        .full_or_irdy(full_or_irdy), .almost_full(almost_full),
        .half_full(half_full), .ae_ofs(ae_ofs)
    );

    dmf_sync #(.W(AW + 1)) u_w2r (.clk(rd_clk), .rst(rst), .d(wgray), .q(wgray_s));
    dmf_sync #(.W(AW + 1)) u_r2w (.clk(wr_clk), .rst(rst), .d(rgray), .q(rgray_s));

    dmf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
        .clk(rd_clk), .rst(rst), .fwft_mode(fwft_mode), .rd_en(rd_en),
        .wgray_s(wgray_s), .mem_rdata(mem_rdata), .ae_ofs(ae_ofs),
        .mem_addr(raddr), .rgray(rgray), .rd_data(rd_data),
        .empty_or_rdy(empty_or_rdy), .almost_empty(almost_empty)
    );
endmodule

// File: tb/dual_mode_fifo_bench.sv
`timescale 1ns/1ps
module dual_mode_fifo_bench;
    localparam int DW = 18;
    localparam int AW = 4;
    localparam int DEPTH = 1 << AW;

    logic wclk = 1'b0, rclk = 1'b0;
    logic rst, fwft, we, ld, re;
    logic [DW-1:0] din;
    logic [DW-1:0] dout;
    logic eo, fi, ae, af, hf;
    int total = 0, bad = 0;
    bit done = 0;

    always #10 wclk = ~wclk;
    initial begin
        #7;
        forever #10 rclk = ~rclk;
    end

    dual_mode_fifo #(.DW(DW), .AW(AW)) u_dual_mode_fifo (
        .wr_clk(wclk), .rd_clk(rclk), .rst(rst), .fwft_mode(fwft),
        .wr_en(we), .load_en(ld), .wr_data(din), .rd_en(re),
        .rd_data(dout), .empty_or_rdy(eo), .full_or_irdy(fi),
        .almost_empty(ae), .almost_full(af), .half_full(hf)
    );

    function automatic logic [DW-1:0] val(input int i);
        return DW'(i * 37 + 5);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [DW-1:0] v);
        @(negedge wclk); we = 1'b1; din = v;
        @(negedge wclk); we = 1'b0;
    endtask

    task automatic pop();
        @(negedge rclk); re = 1'b1;
        @(negedge rclk); re = 1'b0;
    endtask

    task automatic load_word(input logic [DW-1:0] v);
        @(negedge wclk); ld = 1'b1; we = 1'b1; din = v;
        @(negedge wclk); we = 1'b0;
    endtask

    task automatic end_load();
        @(negedge wclk); ld = 1'b0;
        @(negedge wclk);
    endtask

    task automatic settle();
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
    endtask

    task automatic do_reset(input logic mode);
        rst = 1'b1; fwft = mode;
        repeat (5) @(negedge wclk);
        rst = 1'b0;
        settle();
    endtask

    initial begin
        rst = 1'b1; fwft = 1'b0; we = 1'b0; ld = 1'b0; re = 1'b0; din = '0;
        do_reset(1'b0);
        chk("R1 std flags", 32'({eo, fi, ae, af, hf}), 32'b10100);
        chk("R1 std data", 32'(dout), 32'h0);

        // R7: session one sets AE=9, session two restarts at AE: 3, AF=5, wraps AE=2
        load_word(DW'(9));
        end_load();
        load_word(DW'(3));
        load_word(DW'(5));
        load_word(DW'(2));
        end_load();
        settle();
        chk("R7 load left FIFO empty", 32'(eo), 32'h1);

        for (int n = 1; n <= DEPTH; n++) begin
            push(val(n - 1));
            settle();
            chk($sformatf("R4/R8/R9/R10 std level %0d", n), 32'({eo, fi, ae, af, hf}),
                32'({1'b0, n == DEPTH, n <= 2, (DEPTH - n) <= 5, n > DEPTH / 2}));
        end

        push(DW'(18'h3ABC));
        settle();
        chk("R5 still full", 32'(fi), 32'h1);

        for (int i = 0; i < DEPTH; i++) begin
            pop();
            chk($sformatf("R2 order word %0d", i), 32'(dout), 32'(val(i)));
        end
        settle();
        chk("R6 empty after drain", 32'(eo), 32'h1);
        pop();
        chk("R6 empty read holds, R5 word dropped", 32'(dout), 32'(val(DEPTH - 1)));

        push(DW'(18'h2AA));
        settle();
        chk("R2 no output before read", 32'(dout), 32'(val(DEPTH - 1)));
        chk("R2 not empty", 32'(eo), 32'h0);
        pop();
        chk("R2 read delivers word", 32'(dout), 32'h2AA);

        do_reset(1'b1);
        chk("R1 fwft flags", 32'({eo, fi, ae, af, hf}), 32'b01100);
        pop();
        chk("R6 fwft read not ready", 32'(dout), 32'h0);

        push(val(0));
        chk("R3 not yet ready", 32'(eo), 32'h0);
        repeat (4) @(negedge rclk);
        chk("R3 fall-through ready", 32'(eo), 32'h1);
        chk("R3 fall-through data", 32'(dout), 32'(val(0)));

        for (int k = 2; k <= DEPTH + 1; k++) begin
            push(val(k - 1));
            settle();
            chk($sformatf("R4/R8/R9/R10 fwft level %0d", k), 32'({eo, fi, ae, af, hf}),
                32'({1'b1, (k - 1) < DEPTH, k <= 7, (DEPTH + 1 - k) <= 7, (k - 1) > DEPTH / 2}));
        end

        push(DW'(18'h1234));
        settle();
        chk("R5 fwft input not ready", 32'(fi), 32'h0);

        for (int i = 0; i <= DEPTH; i++) begin
            chk($sformatf("R3 fwft word %0d", i), 32'(dout), 32'(val(i)));
            pop();
        end
        settle();
        chk("R3 ready drops after drain", 32'(eo), 32'h0);
        chk("R6 fwft output held", 32'(dout), 32'(val(DEPTH)));
        pop();
        chk("R6 fwft read while not ready, R5 word dropped", 32'(dout), 32'(val(DEPTH)));

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule